// File: doc/BRIEF.md
# Windowed Approximate Unsigned Multiplier

This block multiplies two 16-bit unsigned operands and returns a 32-bit approximate product using one 8x8 multiply instead of a full 16x16 array. Each operand is reduced to a single byte before the multiply. If its upper byte holds any set bit, that upper byte is kept. If not, the lower byte is kept. A one-bit window flag records the choice.

The two kept bytes go into an exact 8x8 core. The core is built from four 4x4 column-wise (vertical and crosswise) sub-multipliers, one for each pairing of nibbles. Ripple-carry adders merge their partial results. A half adder combines the two window flags. Its carry selects a 16-bit left shift of the core product. Otherwise its sum selects an 8-bit shift. When neither is set, the product is not shifted. All bits outside the shifted product are zero.

The block is purely combinational. It suits error-tolerant arithmetic in signal-processing datapaths, where a small error that only ever rounds the result down is acceptable in exchange for a much smaller multiplier.

Top module: `apx_seg_mul`

## Requirements
- R1: An operand's window flag is 1, and its kept byte is bits [15:8], exactly when bits [15:8] are not all zero.
- R2: When an operand's bits [15:8] are all zero, its kept byte is bits [7:0].
- R3: If either operand is zero, the product is zero.
- R4: When both window flags are 0, the result equals the core product with no shift, and bits [31:16] are zero.
- R5: When exactly one window flag is 1 (half-adder sum 1, carry 0), the result is the core product shifted left by 8, and bits [7:0] and [31:24] are zero.
- R6: When both window flags are 1 (half-adder carry 1), the result is the core product shifted left by 16, and bits [15:0] are zero.
- R7: When every set bit of each operand lies inside its selected window, the result equals the exact product.
- R8: The 8x8 core is exact. Operands 19 and 15 (both below 256) give 285, and every byte pair gives its full 16-bit product.
- R9: Operands 5110 and 15 give 72960.
- R10: The result never exceeds the exact product of the two operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First unsigned operand |
| opb_i | input | 16 | Second unsigned operand |
| prod_o | output | 32 | Approximate unsigned product |

## Verification
The bench drives four classes of operand pairs:
- Pairs with both upper bytes zero test the exact core alone.
- Pairs with one upper byte set test the 8-bit shift path.
- Pairs with both upper bytes set test the 16-bit shift path.
- Pairs with a zero operand confirm the result is zero.

Within-window pairs, whose low bytes are cleared whenever their high bytes are used, separate a correct window rule from one that truncates in the wrong place, because only those pairs must come out exact. A large run of random pairs, with upper bytes masked to zero about half the time, is compared with a behavioural model of the window rule. That run also checks that the result never exceeds the exact product.

// File: rtl/apx_pkg.sv
// Shared sizing for the windowed approximate multiplier.
// Assumes the operand width is twice the segment width and the
// segment width is twice the nibble width used by the core.
package apx_pkg;
    parameter int OP_W   = 16;
    parameter int SEG_W  = OP_W / 2;
    parameter int NIB_W  = SEG_W / 2;
    parameter int CORE_W = 2 * SEG_W;
    parameter int PROD_W = 2 * OP_W;
endpackage

// File: rtl/apx_rca.sv
// Ripple-carry adder of W bits built from a chain of full adders.
// Assumes nothing about its inputs; carry out is bit W of the sum.
module apx_rca #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] s_o,
    output logic         co_o
);
    logic [W:0] c;

    assign c[0] = ci_i;

    // one full adder per bit, carry rippling upward
    for (genvar k = 0; k < W; k++) begin : g_fa
        assign s_o[k]  = a_i[k] ^ b_i[k] ^ c[k];
        assign c[k+1]  = (a_i[k] & b_i[k]) | (c[k] & (a_i[k] ^ b_i[k]));
    end

    assign co_o = c[W];
endmodule

// File: rtl/apx_vc_mul4.sv
// 4x4 unsigned multiplier formed column by column: each column sums
// its AND-gate bit products plus the carry of the column below, the
// low bit is the result bit and the rest carries on; the last carry
// becomes the top result bit. Assumes 4-bit operands (three-bit
// column accumulator is wide enough for that size).
module apx_vc_mul4 #(
    parameter int NW = apx_pkg::NIB_W
) (
    input  logic [NW-1:0]   a_i,
    input  logic [NW-1:0]   b_i,
    output logic [2*NW-1:0] p_o
);
    localparam int COLS = 2 * NW - 1;

    logic [2:0] carry_last;

    // column-wise accumulation of crosswise bit products
    always_comb begin
        logic [2:0] carry;
        logic [2:0] acc;
        carry = '0;
        p_o   = '0;
        for (int k = 0; k < COLS; k++) begin
            acc = carry;
            for (int i = 0; i < NW; i++) begin
                if ((k - i) >= 0 && (k - i) < NW) begin
                    acc = acc + 3'(a_i[i] & b_i[k-i]);
                end
            end
            p_o[k] = acc[0];
            carry  = acc >> 1;
        end
        p_o[2*NW-1] = carry[0];
        carry_last  = carry;
    end

    // R8: the last column never carries more than one bit
    always_comb begin
        // R8
        col_carry_chk: assert (carry_last[2:1] == 2'b00)
            else $error("column carry overflow");
    end

    // R8: the sub-multiplier is exact
    always_comb begin
        // R8
        sub_exact_chk: assert (p_o == (2*NW)'(a_i) * (2*NW)'(b_i))
            else $error("4x4 product wrong");
    end
endmodule

// File: rtl/apx_vc_mul8.sv
// Exact 8x8 unsigned multiplier made of four 4x4 column-wise blocks,
// one per nibble pairing, merged with three ripple-carry adders.
// Assumes SEG_W = 2 * NIB_W.
module apx_vc_mul8 #(
    parameter int SW = apx_pkg::SEG_W
) (
    input  logic [SW-1:0]   a_i,
    input  logic [SW-1:0]   b_i,
    output logic [2*SW-1:0] p_o
);
    localparam int HW = SW / 2;

    logic [SW-1:0] pp_ll, pp_hl, pp_lh, pp_hh;
    logic [SW-1:0] mid_s, mid2_s, top_s, top_b;
    logic          mid_c, mid2_c, top_c;

    apx_vc_mul4 #(.NW(HW)) u_ll (.a_i(a_i[HW-1:0]),  .b_i(b_i[HW-1:0]),  .p_o(pp_ll));
    apx_vc_mul4 #(.NW(HW)) u_hl (.a_i(a_i[SW-1:HW]), .b_i(b_i[HW-1:0]),  .p_o(pp_hl));
    apx_vc_mul4 #(.NW(HW)) u_lh (.a_i(a_i[HW-1:0]),  .b_i(b_i[SW-1:HW]), .p_o(pp_lh));
    apx_vc_mul4 #(.NW(HW)) u_hh (.a_i(a_i[SW-1:HW]), .b_i(b_i[SW-1:HW]), .p_o(pp_hh));

    // sum of the two cross terms
    apx_rca #(.W(SW)) u_add_mid (
        .a_i(pp_hl), .b_i(pp_lh), .ci_i(1'b0), .s_o(mid_s), .co_o(mid_c));

    // fold in the upper nibble of the low-low term
    apx_rca #(.W(SW)) u_add_mid2 (
        .a_i(mid_s), .b_i({{HW{1'b0}}, pp_ll[SW-1:HW]}), .ci_i(1'b0),
        .s_o(mid2_s), .co_o(mid2_c));

    // middle carries (at most one set) join the upper half of the middle sum
    assign top_b = {{(HW-1){1'b0}}, mid_c | mid2_c, mid2_s[SW-1:HW]};

    apx_rca #(.W(SW)) u_add_top (
        .a_i(pp_hh), .b_i(top_b), .ci_i(1'b0), .s_o(top_s), .co_o(top_c));

    assign p_o = {top_s, mid2_s[HW-1:0], pp_ll[HW-1:0]};

    // R8: the two middle carries are never both set
    always_comb begin
        // R8
        mid_carry_chk: assert (!(mid_c && mid2_c))
            else $error("double middle carry");
    end

    // R8: the top adder never overflows
    always_comb begin
        // R8
        top_carry_chk: assert (!top_c)
            else $error("top adder overflow");
    end

    // R8: the core is exact
    always_comb begin
        // R8
        core_exact_chk: assert (p_o == (2*SW)'(a_i) * (2*SW)'(b_i))
            else $error("8x8 core product wrong");
    end
endmodule

// File: rtl/apx_seg_pick.sv
// Keeps one byte of a 16-bit operand: the upper byte when it has any
// set bit, else the lower byte. The flag tells which window was kept.
module apx_seg_pick #(
    parameter int OW = apx_pkg::OP_W,
    parameter int SW = apx_pkg::SEG_W
) (
    input  logic [OW-1:0] op_i,
    output logic [SW-1:0] seg_o,
    output logic          hi_o
);
    // leading-one window choice
    always_comb begin
        hi_o  = |op_i[OW-1:SW];
        seg_o = hi_o ? op_i[OW-1:SW] : op_i[SW-1:0];
    end

    // R1: flag set implies the kept byte is the upper byte and nonzero
    always_comb begin
        // R1
        hi_win_chk: assert (!hi_o || (seg_o == op_i[OW-1:SW] && seg_o != '0))
            else $error("high window selection wrong");
    end

    // R2: flag clear implies the operand fits in the low byte
    always_comb begin
        // R2
        lo_win_chk: assert (hi_o || (OW'(seg_o) == op_i))
            else $error("low window selection wrong");
    end
endmodule

// File: rtl/apx_seg_mul.sv
// Top of the windowed approximate multiplier. Each operand keeps one
// byte; an exact 8x8 core multiplies them; a half adder on the two
// window flags picks a 0, 8 or 16-bit shift through a three-way mux.
// Purely combinational, unsigned operands only.
module apx_seg_mul #(
    parameter int OW = apx_pkg::OP_W
) (
    input  logic [OW-1:0]   opa_i,
    input  logic [OW-1:0]   opb_i,
    output logic [2*OW-1:0] prod_o
);
    localparam int SW = OW / 2;
    localparam int CW = 2 * SW;
    localparam int PW = 2 * OW;

    logic [SW-1:0] seg_a, seg_b;
    logic          hi_a, hi_b;
    logic [CW-1:0] core_p;
    logic          ha_sum, ha_cry;

    apx_seg_pick #(.OW(OW), .SW(SW)) u_pick_a (.op_i(opa_i), .seg_o(seg_a), .hi_o(hi_a));
    apx_seg_pick #(.OW(OW), .SW(SW)) u_pick_b (.op_i(opb_i), .seg_o(seg_b), .hi_o(hi_b));

    apx_vc_mul8 #(.SW(SW)) u_core (.a_i(seg_a), .b_i(seg_b), .p_o(core_p));

    // half adder on the window flags
    assign ha_sum = hi_a ^ hi_b;
    assign ha_cry = hi_a & hi_b;

    // three-way output shift mux
    always_comb begin
        if (ha_cry)      prod_o = PW'(core_p) << (2 * SW);
        else if (ha_sum) prod_o = PW'(core_p) << SW;
        else             prod_o = PW'(core_p);
    end

    // R3: a zero operand yields zero
    always_comb begin
        // R3
        zero_op_chk: assert (!(opa_i == '0 || opb_i == '0) || prod_o == '0)
            else $error("zero operand gave nonzero product");
    end

    // R4: no shift keeps the upper half clear
    always_comb begin
        // R4
        no_shift_chk: assert (hi_a || hi_b || prod_o[PW-1:CW] == '0)
            else $error("unshifted product has upper bits");
    end

    // R6: full shift keeps the lower half clear
    always_comb begin
        // R6
        full_shift_chk: assert (!(hi_a && hi_b) || prod_o[CW-1:0] == '0)
            else $error("16-bit shifted product has lower bits");
    end

    // R10: approximation only ever rounds down
    always_comb begin
        // R10
        no_over_chk: assert (prod_o <= PW'(opa_i) * PW'(opb_i))
            else $error("approximate product exceeds exact");
    end
endmodule

// File: tb/apx_seg_mul_bench.sv
// Self-checking bench: behavioural model of the window rule, compared
// once per clock against the combinational result.
module apx_seg_mul_bench;
    logic        clk = 1'b0;
    logic [15:0] opa, opb;
    logic [31:0] prod;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    apx_seg_mul u_apx_seg_mul (.opa_i(opa), .opb_i(opb), .prod_o(prod));

    // behavioural model: pick window, multiply, shift by 8 per high flag
    function automatic longint ref_mul(input int a, input int b);
        int fa, fb, sa, sb;
        fa = (a >= 256) ? 1 : 0;
        fb = (b >= 256) ? 1 : 0;
        sa = fa ? (a / 256) : a;
        sb = fb ? (b / 256) : b;
        return longint'(sa) * longint'(sb) * (longint'(1) << (8 * (fa + fb)));
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        @(negedge clk);
        opa = 16'(a);
        opb = 16'(b);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        opa = '0;
        opb = '0;
        // R3: idle zero inputs give zero
        apply(0, 0);
        check("R3 idle", prod, 0);
        apply(0, 65535);
        check("R3 a zero", prod, 0);
        apply(40000, 0);
        check("R3 b zero", prod, 0);
        // R8: core alone
        apply(19, 15);
        check("R8 19x15", prod, 285);
        apply(255, 255);
        check("R8 255x255", prod, 65025);
        // R9: documented approximation
        apply(5110, 15);
        check("R9 5110x15", prod, 72960);
        // R4: both low windows, exact
        apply(200, 100);
        check("R4 low-low", prod, 20000);
        // R5: one high window
        apply(15, 5110);
        check("R5 low-high", prod, 72960);
        apply(256, 1);
        check("R5 256x1", prod, 256);
        // R6: both high windows
        apply(16'hFF00, 16'hFF00);
        check("R6 hi-hi", prod, 64'hFF00 * 64'hFF00);
        apply(16'h0100, 16'h01FF);
        check("R6 drop low", prod, 32'h00010000);
        // R1 R2: boundary at 255/256
        apply(255, 256);
        check("R1 R2 boundary", prod, 255 * 256);
        apply(257, 3);
        check("R1 drop low bit", prod, 768);
        // R7: within-window operands are exact
        apply(16'hAB00, 16'h00CD);
        check("R7 hi-lo exact", prod, 32'hAB00 * 32'h00CD);
        apply(16'h7F00, 16'h3100);
        check("R7 hi-hi exact", prod, 32'h7F00 * 32'h3100);
        // R10 R7 R5 R6: random sweep against the model
        for (int i = 0; i < 3000; i++) begin
            int a, b;
            a = int'($urandom_range(0, 65535));
            b = int'($urandom_range(0, 65535));
            if ($urandom_range(0, 1) == 0) a = a % 256;
            if ($urandom_range(0, 1) == 0) b = b % 256;
            apply(a, b);
            check("R10 model", prod, ref_mul(a, b));
            if (longint'(prod) > longint'(a) * longint'(b))
                check("R10 bound", prod, longint'(a) * longint'(b));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule